// File: doc/BRIEF.md
# Multi-way stream buffer prefetcher

This block sits next to a level-one cache and follows several sequential address streams at once. It holds a small set of stream buffers. Each buffer is a ring of line slots, and every slot carries a line tag, a valid flag, an arrived flag and the line data. The cache presents each demand access that missed in its own arrays on the lookup port. The block compares the lookup against the oldest slot (the head) of every buffer and nothing else.

When a head matches and its data has arrived, the line is returned on the refill output. The head slot is then reused for the line one beyond the end of that stream, so the buffer keeps running ahead of the demand stream. When no head matches, the lookup is answered as a miss and the cache fetches the line itself. The least recently used buffer is flushed and restarted on the lines that follow the missing one.

Prefetch requests from all buffers go to memory through a single request port under round-robin arbitration. Each buffer has at most one request in flight. Responses carry the index of the buffer that asked. An invalidate port drops any buffered copy of a line that another agent has written.

Top module: `stream_prefetch`

## Requirements
- R1: While reset is applied and right after it, `lk_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A lookup is accepted on a rising edge with `lk_valid` and `lk_ready` both high. If no buffer head holds its line (line = address bits 31..6), `rsp_valid` pulses for one cycle with `rsp_hit` 0 and `rsp_addr` equal to the lookup address, one edge after acceptance.
- R3: After such a miss on line L, one buffer issues memory requests for lines L+1, L+2, L+3 and L+4, in that order. `mem_req_addr` is line-aligned, with bits 5..0 zero.
- R4: A lookup whose line equals a buffer head whose data has arrived answers one edge after acceptance with `rsp_hit` 1 and `rsp_data` equal to the memory data of that line. That buffer then advances and appends the line one beyond its last slot, so a sequential sweep keeps hitting.
- R5: Lines held in a buffer behind its head never match a lookup; such a lookup is a miss.
- R6: A lookup that matches a head whose data has not yet arrived holds its response until the data is in, then hits. No second memory request for that line is issued.
- R7: Four buffers follow four independent interleaved streams at the same time, all hitting.
- R8: A miss restarts the buffer whose last allocation or hit is the oldest. The flushed stream's lines then miss, and responses still due to that buffer from its old stream are discarded.
- R9: Memory requests carry the buffer index in `mem_req_id` (0..3). A buffer never has more than one request outstanding. Buffers take turns round-robin, and a request held off by `mem_req_ready` low stays presented.
- R10: `inv_valid` with line `inv_line` clears every buffered slot whose tag equals it, at the head or behind it. A later lookup of that line misses. An invalidate of a line that no buffer holds has no effect.
- R11: An invalidate in the same cycle as a lookup of the same line is decided takes precedence: the lookup is answered as a miss.
- R12: `lk_ready` is 0 from the edge that accepts a lookup until that lookup is answered; only one lookup is in progress at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| lk_valid | input | 1 | Demand lookup request (an access that missed in the cache) |
| lk_ready | output | 1 | Lookup port can accept a request |
| lk_addr | input | 32 | Byte address of the demand access |
| rsp_valid | output | 1 | One-cycle answer to the accepted lookup |
| rsp_hit | output | 1 | Line supplied from a buffer head |
| rsp_addr | output | 32 | Address of the answered lookup |
| rsp_data | output | 512 | Line data for the cache refill, valid when rsp_hit is 1 |
| inv_valid | input | 1 | Invalidate request |
| inv_line | input | 26 | Line address to drop from every buffer |
| mem_req_valid | output | 1 | Prefetch request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Line-aligned byte address requested |
| mem_req_id | output | 2 | Index of the requesting buffer |
| mem_rsp_valid | input | 1 | Memory returns a line |
| mem_rsp_id | input | 2 | Buffer index the returned line belongs to |
| mem_rsp_data | input | 512 | Returned line data |

## Verification
The delicate overlap is an invalidate landing in the very cycle a pending lookup is resolved against a buffer head. The bench raises `lk_valid` for one cycle and then drives `inv_valid` for the same line in the next cycle, which is the cycle the lookup is decided. It expects a miss response with no line. A second run invalidates a line just behind the head in that same cycle. In that case the bench expects the head hit to proceed and the following sequential lookup to miss.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  // Outcome of evaluating a pending lookup against the buffer heads
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HIT  = 2'd1,
    LK_WAIT = 2'd2,
    LK_MISS = 2'd3
  } lk_res_e;

endpackage

// File: rtl/sbp_rr_arb.sv
module sbp_rr_arb #(
  parameter int NUM  = 4,
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NUM-1:0]  req_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [ID_W-1:0] id_o,
  output logic [NUM-1:0]  gnt_o
);

  logic [ID_W-1:0] ptr_q, ptr_n;

  always_comb begin
    valid_o = 1'b0;
    id_o    = ptr_q;
    for (int k = 0; k < NUM; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % NUM;
      if (!valid_o && req_i[idx]) begin
        valid_o = 1'b1;
        id_o    = ID_W'(idx);
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    ptr_n = ptr_q;
    if (valid_o && ready_i) begin
      gnt_o = NUM'(1) << id_o;
      ptr_n = (id_o == ID_W'(NUM - 1)) ? '0 : id_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o);

endmodule

// File: rtl/sbp_lru.sv
module sbp_lru #(
  parameter int NUM  = 4,
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            touch_i,
  input  logic [ID_W-1:0] touch_id_i,
  output logic [ID_W-1:0] victim_o
);

  logic [ID_W-1:0] age_q [NUM];
  logic [ID_W-1:0] age_n [NUM];
  logic [NUM-1:0]  old_vec;

  always_comb begin
    for (int i = 0; i < NUM; i++) begin
      age_n[i] = age_q[i];
      if (touch_i) begin
        if (ID_W'(i) == touch_id_i)             age_n[i] = '0;
        else if (age_q[i] < age_q[touch_id_i])  age_n[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < NUM; i++) begin
      old_vec[i] = (age_q[i] == ID_W'(NUM - 1));
      if (old_vec[i]) victim_o = ID_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) age_q[i] <= ID_W'(NUM - 1 - i);
    end else if (touch_i) begin
      for (int i = 0; i < NUM; i++) age_q[i] <= age_n[i];
    end
  end

  // R8
  lru_unique_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(old_vec));

endmodule

// File: rtl/sbp_buffer.sv
module sbp_buffer #(
  parameter int DEPTH  = 4,
  parameter int LA_W   = 26,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [LA_W-1:0]   alloc_base_i,
  input  logic              pop_i,
  input  logic              inv_i,
  input  logic [LA_W-1:0]   inv_line_i,
  input  logic [LA_W-1:0]   look_line_i,
  output logic              head_match_o,
  output logic              head_avail_o,
  output logic [LINE_W-1:0] head_data_o,
  output logic              req_o,
  output logic [LA_W-1:0]   req_line_o,
  input  logic              gnt_i,
  input  logic              rsp_i,
  input  logic [LINE_W-1:0] rsp_data_i
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [LA_W-1:0]   tag_q [DEPTH];
  logic [LA_W-1:0]   tag_n [DEPTH];
  logic [LINE_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  val_q, val_n, avail_q, avail_n, inv_hit;
  logic [PW-1:0]     hd_q, hd_n, iss_q, iss_n, out_q, out_n;
  logic [CW-1:0]     unsent_q, unsent_n;
  logic              pend_q, pend_n, drop_q, drop_n;
  logic [LA_W-1:0]   tail_q, tail_n;
  logic              data_we;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) inv_hit[i] = inv_i && (tag_q[i] == inv_line_i);
  end

  assign head_match_o = val_q[hd_q] && (tag_q[hd_q] == look_line_i) &&
                        !(inv_i && (inv_line_i == look_line_i));
  assign head_avail_o = avail_q[hd_q];
  assign head_data_o  = data_q[hd_q];
  assign req_o        = !pend_q && (unsent_q != '0);
  assign req_line_o   = tag_q[iss_q];
  assign data_we      = rsp_i && pend_q && !drop_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) tag_n[i] = tag_q[i];
    val_n    = val_q & ~inv_hit;
    avail_n  = avail_q;
    hd_n     = hd_q;
    iss_n    = iss_q;
    out_n    = out_q;
    unsent_n = unsent_q;
    pend_n   = pend_q;
    drop_n   = drop_q;
    tail_n   = tail_q;
    if (gnt_i) begin
      out_n    = iss_q;
      iss_n    = wrap_inc(iss_q);
      unsent_n = unsent_q - 1'b1;
      pend_n   = 1'b1;
    end
    if (rsp_i && pend_q) begin
      pend_n = 1'b0;
      drop_n = 1'b0;
      if (!drop_q) avail_n[out_q] = 1'b1;
    end
    if (pop_i) begin
      tag_n[hd_q]   = tail_q;
      val_n[hd_q]   = 1'b1;
      avail_n[hd_q] = 1'b0;
      tail_n        = tail_q + 1'b1;
      hd_n          = wrap_inc(hd_q);
      unsent_n      = unsent_n + 1'b1;
    end
    if (alloc_i) begin
      for (int i = 0; i < DEPTH; i++) tag_n[i] = alloc_base_i + LA_W'(i);
      val_n    = '1;
      avail_n  = '0;
      hd_n     = '0;
      iss_n    = '0;
      unsent_n = CW'(DEPTH);
      tail_n   = alloc_base_i + LA_W'(DEPTH);
      if (pend_n) drop_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
      val_q    <= '0;
      avail_q  <= '0;
      hd_q     <= '0;
      iss_q    <= '0;
      out_q    <= '0;
      unsent_q <= '0;
      pend_q   <= 1'b0;
      drop_q   <= 1'b0;
      tail_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= tag_n[i];
      val_q    <= val_n;
      avail_q  <= avail_n;
      hd_q     <= hd_n;
      iss_q    <= iss_n;
      out_q    <= out_n;
      unsent_q <= unsent_n;
      pend_q   <= pend_n;
      drop_q   <= drop_n;
      tail_q   <= tail_n;
    end
  end

  always_ff @(posedge clk) begin
    if (data_we) data_q[out_q] <= rsp_data_i;
  end

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_i |-> !pend_q);

  // R9
  grant_marks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_i |=> pend_q);

  // R4
  pop_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> head_avail_o && head_match_o);

  // R3
  restart_first_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> req_line_o == $past(alloc_base_i));

endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch #(
  parameter int NUM_BUF    = 4,
  parameter int DEPTH      = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LINE_W     = LINE_BYTES * 8,
  parameter int LA_W       = ADDR_W - $clog2(LINE_BYTES),
  parameter int ID_W       = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [LINE_W-1:0] rsp_data,
  input  logic              inv_valid,
  input  logic [LA_W-1:0]   inv_line,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ID_W-1:0]   mem_req_id,
  input  logic              mem_rsp_valid,
  input  logic [ID_W-1:0]   mem_rsp_id,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  import sbp_pkg::*;

  localparam int OFF_W = ADDR_W - LA_W;

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Pending lookup
  logic              pend_q, pend_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LA_W-1:0]   pline;
  lk_res_e           res;

  logic [NUM_BUF-1:0] match_v, avail_v, hitav_v, pop_v, alloc_v, req_v, gnt_v, rsp_v;
  logic [LINE_W-1:0]  hd_data [NUM_BUF];
  logic [LA_W-1:0]    req_line [NUM_BUF];
  logic [ID_W-1:0]    hit_id, victim_id, arb_id;
  logic               lru_touch;

  logic              rsp_valid_q, rsp_hit_q;
  logic [ADDR_W-1:0] rsp_addr_q;
  logic [LINE_W-1:0] rsp_data_q;

  assign pline    = addr_q[ADDR_W-1:OFF_W];
  assign lk_ready = !pend_q;
  assign hitav_v  = match_v & avail_v;

  always_comb begin
    hit_id = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (hitav_v[i]) hit_id = ID_W'(i);
    end
  end

  always_comb begin
    if (!pend_q)            res = LK_IDLE;
    else if (|hitav_v)      res = LK_HIT;
    else if (|match_v)      res = LK_WAIT;
    else                    res = LK_MISS;
  end

  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) begin
      pop_v[i]   = (res == LK_HIT)  && (hit_id    == ID_W'(i));
      alloc_v[i] = (res == LK_MISS) && (victim_id == ID_W'(i));
      rsp_v[i]   = mem_rsp_valid    && (mem_rsp_id == ID_W'(i));
    end
  end

  assign lru_touch = (res == LK_HIT) || (res == LK_MISS);

  always_comb begin
    pend_n = pend_q;
    addr_n = addr_q;
    if (lk_valid && lk_ready) begin
      pend_n = 1'b1;
      addr_n = lk_addr;
    end else if (lru_touch) begin
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q      <= 1'b0;
      addr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_addr_q  <= '0;
    end else begin
      pend_q      <= pend_n;
      addr_q      <= addr_n;
      rsp_valid_q <= lru_touch;
      if (lru_touch) begin
        rsp_hit_q  <= (res == LK_HIT);
        rsp_addr_q <= addr_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (res == LK_HIT) rsp_data_q <= hd_data[hit_id];
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_addr  = rsp_addr_q;
  assign rsp_data  = rsp_data_q;

  // Stream buffers
  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    sbp_buffer #(
      .DEPTH  (DEPTH),
      .LA_W   (LA_W),
      .LINE_W (LINE_W)
    ) u_buf (
      .clk          (clk),
      .rst_n        (rst_int_n),
      .alloc_i      (alloc_v[b]),
      .alloc_base_i (pline + 1'b1),
      .pop_i        (pop_v[b]),
      .inv_i        (inv_valid),
      .inv_line_i   (inv_line),
      .look_line_i  (pline),
      .head_match_o (match_v[b]),
      .head_avail_o (avail_v[b]),
      .head_data_o  (hd_data[b]),
      .req_o        (req_v[b]),
      .req_line_o   (req_line[b]),
      .gnt_i        (gnt_v[b]),
      .rsp_i        (rsp_v[b]),
      .rsp_data_i   (mem_rsp_data)
    );
  end

  sbp_lru #(
    .NUM  (NUM_BUF),
    .ID_W (ID_W)
  ) u_lru (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .touch_i    (lru_touch),
    .touch_id_i ((res == LK_HIT) ? hit_id : victim_id),
    .victim_o   (victim_id)
  );

  sbp_rr_arb #(
    .NUM  (NUM_BUF),
    .ID_W (ID_W)
  ) u_arb (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req_i   (req_v),
    .ready_i (mem_req_ready),
    .valid_o (mem_req_valid),
    .id_o    (arb_id),
    .gnt_o   (gnt_v)
  );

  assign mem_req_id   = arb_id;
  assign mem_req_addr = {req_line[arb_id], {OFF_W{1'b0}}};

  // R12
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_valid && lk_ready |=> !lk_ready);

  // R2
  single_pulse_rsp_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |=> !rsp_valid);

  // R12
  rsp_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> $past(pend_q));

  // R11
  inv_wins_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pend_q && inv_valid && (inv_line == pline) |=> !(rsp_valid && rsp_hit));

endmodule

// File: tb/stream_prefetch_tb.sv
`timescale 1ns/1ps
module stream_prefetch_tb;

  localparam int LA_W   = 26;
  localparam int LINE_W = 512;

  logic              clk;
  logic              rst_n;
  logic              lk_valid;
  logic              lk_ready;
  logic [31:0]       lk_addr;
  logic              rsp_valid;
  logic              rsp_hit;
  logic [31:0]       rsp_addr;
  logic [LINE_W-1:0] rsp_data;
  logic              inv_valid;
  logic [LA_W-1:0]   inv_line;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [31:0]       mem_req_addr;
  logic [1:0]        mem_req_id;
  logic              mem_rsp_valid;
  logic [1:0]        mem_rsp_id;
  logic [LINE_W-1:0] mem_rsp_data;

  stream_prefetch u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_ready      (lk_ready),
    .lk_addr       (lk_addr),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_addr      (rsp_addr),
    .rsp_data      (rsp_data),
    .inv_valid     (inv_valid),
    .inv_line      (inv_line),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_id    (mem_req_id),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_id    (mem_rsp_id),
    .mem_rsp_data  (mem_rsp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk;
  int n_fail;
  int cyc;
  int mem_lat;
  bit done;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [LINE_W-1:0] fdata(input logic [LA_W-1:0] line);
    logic [LINE_W-1:0] d;
    for (int k = 0; k < 16; k++)
      d[k*32 +: 32] = {6'h0, line} * 32'h9E3779B1 + k * 32'h01010101;
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Memory responder: FIFO of accepted requests, each answered after mem_lat cycles
  int               q_id   [64];
  logic [LA_W-1:0]  q_line [64];
  int               q_t    [64];
  int               q_hd, q_tl;
  int               out_cnt [4];
  logic [LA_W-1:0]  log_line [1024];
  int               log_id   [1024];
  int               n_req;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (out_cnt[mem_req_id] != 0)
        chk(1'b0, "R9 second outstanding request", out_cnt[mem_req_id] + 1, 1);
      chk(mem_req_addr[5:0] == 6'd0, "R3 request line-aligned", mem_req_addr, {mem_req_addr[31:6], 6'd0});
      out_cnt[mem_req_id]++;
      q_id[q_tl % 64]   = int'(mem_req_id);
      q_line[q_tl % 64] = mem_req_addr[31:6];
      q_t[q_tl % 64]    = cyc;
      q_tl++;
      if (n_req < 1024) begin
        log_line[n_req] = mem_req_addr[31:6];
        log_id[n_req]   = int'(mem_req_id);
      end
      n_req++;
    end
    if (q_hd != q_tl && cyc >= q_t[q_hd % 64] + mem_lat) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_id    = 2'(q_id[q_hd % 64]);
      mem_rsp_data  = fdata(q_line[q_hd % 64]);
      out_cnt[q_id[q_hd % 64]]--;
      q_hd++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic inv(input logic [LA_W-1:0] line);
    @(negedge clk);
    inv_valid = 1'b1;
    inv_line  = line;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  // Issue one lookup; if inv_same is set, invalidate inv_l in the deciding cycle
  task automatic lookup(input logic [LA_W-1:0] line, input logic [5:0] off, input bit exp_hit,
                        input string tag, input bit inv_same, input logic [LA_W-1:0] inv_l,
                        output int lat);
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = {line, off};
    @(negedge clk);
    lk_valid = 1'b0;
    lat = 1;
    chk(lk_ready == 1'b0, {tag, " R12 busy while pending"}, lk_ready, 0);
    if (inv_same) begin
      inv_valid = 1'b1;
      inv_line  = inv_l;
    end
    while (!rsp_valid && lat < 500) begin
      @(negedge clk);
      inv_valid = 1'b0;
      lat++;
    end
    inv_valid = 1'b0;
    chk(rsp_valid, {tag, " response seen"}, rsp_valid, 1);
    chk(rsp_hit == exp_hit, {tag, " hit flag"}, rsp_hit, exp_hit);
    chk(rsp_addr == {line, off}, {tag, " response address"}, rsp_addr, {line, off});
    if (exp_hit)
      chk(rsp_data == fdata(line), {tag, " line data"}, rsp_data[63:0], fdata(line)[63:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    int n0;
    int cnt;
    bit ok;
    logic [LA_W-1:0] L, M, N;
    logic [LA_W-1:0] B [4];
    n_chk = 0; n_fail = 0; cyc = 0; done = 1'b0;
    q_hd = 0; q_tl = 0; n_req = 0;
    for (int i = 0; i < 4; i++) out_cnt[i] = 0;
    mem_lat = 3;
    rst_n = 1'b0; lk_valid = 1'b0; lk_addr = '0;
    inv_valid = 1'b0; inv_line = '0; mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0; mem_rsp_id = '0; mem_rsp_data = '0;
    idle(3);
    // R1 reset state
    chk(lk_ready == 1'b1, "R1 lk_ready in reset", lk_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", mem_req_valid, 0);
    rst_n = 1'b1;
    idle(4);
    chk(lk_ready && !rsp_valid && !mem_req_valid, "R1 idle after reset",
        {lk_ready, rsp_valid, mem_req_valid}, 3'b100);

    // R2, R3: cold miss and sequential prefetch
    L  = 26'h0001000;
    n0 = n_req;
    lookup(L, 6'd12, 1'b0, "R2 cold miss", 1'b0, '0, lat);
    chk(lat == 2, "R2 miss latency", lat, 2);
    idle(30);
    chk(n_req - n0 == 4, "R3 four prefetches", n_req - n0, 4);
    for (int j = 0; j < 4; j++)
      chk(log_line[n0 + j] == L + LA_W'(j + 1), "R3 prefetch order", log_line[n0 + j], L + LA_W'(j + 1));

    // R4: sequential sweep over twelve lines, offsets varied
    for (int k = 1; k <= 12; k++) begin
      lookup(L + LA_W'(k), 6'(k * 5), 1'b1, "R4 sequential hit", 1'b0, '0, lat);
      if (k <= 4) chk(lat == 2, "R4 hit latency", lat, 2);
    end

    // R5: an entry behind the head is not compared
    idle(30);
    lookup(L + 26'd14, 6'd0, 1'b0, "R5 behind head misses", 1'b0, '0, lat);
    lookup(L + 26'd13, 6'd3, 1'b1, "R5 head still hits", 1'b0, '0, lat);

    // R6: stall on a head whose data is still in flight
    idle(30);
    mem_lat = 40;
    M  = 26'h0002000;
    n0 = n_req;
    lookup(M, 6'd0, 1'b0, "R6 miss starts stream", 1'b0, '0, lat);
    lookup(M + 26'd1, 6'd7, 1'b1, "R6 stalled hit", 1'b0, '0, lat);
    chk(lat > 20, "R6 response held until data", lat, 21);
    idle(120);
    cnt = 0;
    for (int j = n0; j < n_req && j < 1024; j++)
      if (log_line[j] == M + 26'd1) cnt++;
    chk(cnt == 1, "R6 single request for stalled line", cnt, 1);
    mem_lat = 3;

    // R7: four interleaved streams
    B[0] = 26'h0003000; B[1] = 26'h0004000; B[2] = 26'h0005000; B[3] = 26'h0006000;
    for (int s = 0; s < 4; s++) lookup(B[s], 6'd0, 1'b0, "R7 stream start", 1'b0, '0, lat);
    idle(40);
    for (int r = 1; r <= 3; r++)
      for (int s = 0; s < 4; s++)
        lookup(B[s] + LA_W'(r), 6'(r + s), 1'b1, "R7 interleaved hit", 1'b0, '0, lat);

    // R8: replacement of the least recently used buffer
    lookup(B[0] + 26'd4, 6'd0, 1'b1, "R8 refresh stream 0", 1'b0, '0, lat);
    N = 26'h0007000;
    lookup(N, 6'd0, 1'b0, "R8 new stream", 1'b0, '0, lat);
    idle(40);
    lookup(B[1] + 26'd4, 6'd0, 1'b0, "R8 evicted stream misses", 1'b0, '0, lat);
    idle(30);
    lookup(B[3] + 26'd4, 6'd0, 1'b1, "R8 kept stream 3 hits", 1'b0, '0, lat);
    lookup(B[0] + 26'd5, 6'd0, 1'b1, "R8 kept stream 0 hits", 1'b0, '0, lat);
    lookup(B[2] + 26'd4, 6'd0, 1'b0, "R8 second eviction misses", 1'b0, '0, lat);

    // R10: invalidate at the head, behind the head, and of an absent line
    idle(30);
    inv(B[3] + 26'd5);
    lookup(B[3] + 26'd5, 6'd0, 1'b0, "R10 invalidated head misses", 1'b0, '0, lat);
    idle(30);
    inv(B[3] + 26'd7);
    lookup(B[3] + 26'd6, 6'd0, 1'b1, "R10 head before cleared entry hits", 1'b0, '0, lat);
    lookup(B[3] + 26'd7, 6'd0, 1'b0, "R10 cleared entry misses", 1'b0, '0, lat);
    idle(30);
    inv(26'h0009999);
    lookup(B[3] + 26'd8, 6'd0, 1'b1, "R10 unrelated invalidate no effect", 1'b0, '0, lat);

    // R11: invalidate in the deciding cycle
    idle(30);
    lookup(B[3] + 26'd9, 6'd0, 1'b0, "R11 same-cycle invalidate wins", 1'b1, B[3] + 26'd9, lat);
    chk(lat == 2, "R11 miss latency", lat, 2);
    idle(30);
    lookup(B[3] + 26'd10, 6'd0, 1'b1, "R11 invalidate behind head in deciding cycle", 1'b1,
           B[3] + 26'd11, lat);
    lookup(B[3] + 26'd11, 6'd0, 1'b0, "R11 line cleared in deciding cycle misses", 1'b0, '0, lat);

    // R9: every buffer ends with nothing outstanding and every request answered
    idle(60);
    ok = 1'b1;
    for (int i = 0; i < 4; i++) if (out_cnt[i] != 0) ok = 1'b0;
    chk(ok, "R9 all requests answered", q_tl - q_hd, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule